// File: doc/BRIEF.md
# MDIO Management Slave Frame Engine

This block is the PHY side of a two-wire serial management link. It samples the data line on every rising edge of the management clock and decodes frames. A frame is a start pattern, an opcode, a 5-bit device address, a 5-bit register address, a turnaround and 16 data bits. Frames addressed to this device are turned into single-cycle accesses on a simple internal register port. The block never tristates anything itself. It reports its drive through an output-enable and output-data pair, and the pad logic around it combines these with the pull-up.

After reset, a frame is only accepted once a run of 32 consecutive one bits has been seen on the line. After that single run, frames may start with no preamble at all. One idle (one) bit between transactions is enough for the next start pattern to be found. The device address is held in a local register at address 19h. Its upper 3 bits load from strap inputs at reset and its lower 2 bits load from a port-number input. Software may rewrite it afterwards. The status register at address 01h carries a flag in bit 6 that advertises preamble suppression.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset `mdio_oe`, `reg_we` and `reg_rd` are low, and the device address equals {strap_addr, port_num}, strap bits in the upper three positions. A read of register 19h returns this address in bits 4:0 and zeros above.
- R2: Until 32 consecutive ones have been sampled after reset, no frame is accepted. A start pattern preceded by only 31 ones causes no drive and no strobe.
- R3: Once the initial 32-one run has been seen, a frame that begins directly with the 01 start pattern, with no preamble, is accepted.
- R4: On a read (opcode 10) addressed to this device, `mdio_oe` stays low during both turnaround bits. The block then drives 16 data bits most significant first, one per clock, starting at the clock edge that samples the second turnaround bit. It releases the line after the sixteenth bit.
- R5: On a write (opcode 01) addressed to this device, `reg_we` pulses for exactly one cycle, in the cycle after the sixteenth data bit is sampled. During that pulse `reg_addr` holds the register address and `reg_wdata` holds the data, both received most significant bit first.
- R6: A frame whose device address differs from the local address produces no drive and no strobe. It is followed to its full length, so that a valid frame after one idle bit is still decoded.
- R7: Opcodes 00 and 11 cause no drive and no strobe.
- R8: A single idle bit between the end of one transaction and the next start pattern is sufficient.
- R9: A read of register 01h returns the external data with bit 6 forced to 1.
- R10: A write to register 19h replaces the device address with data bits 4:0 and raises no `reg_we`. Later frames match the new address only.
- R11: Only register addresses 0–6 and 16–31 are implemented. A read of any other address drives all-zero data and raises no `reg_rd`. A write to one raises no `reg_we`.
- R12: For a matched read of an implemented register other than 19h, `reg_rd` pulses for one cycle, during the first turnaround bit, with `reg_addr` valid. The data present on `reg_rdata` in that cycle is what is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to mdc |
| mdio_in | input | 1 | Sampled level of the management data line |
| strap_addr | input | 3 | Strap value for the upper device-address bits, loaded at reset |
| port_num | input | 2 | Port number for the lower device-address bits, loaded at reset |
| mdio_oe | output | 1 | High while the block drives the data line |
| mdio_out | output | 1 | Level to drive when mdio_oe is high |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Write data for the register port |
| reg_we | output | 1 | One-cycle write strobe to the register port |
| reg_rd | output | 1 | One-cycle read strobe to the register port |
| reg_rdata | input | 16 | Read data from the register port, sampled while reg_rd is high |

## Verification
Every cycle, the assertions check the following. Nothing is driven or strobed before the initial preamble. The output enable is only high in the data phase of a matched frame, and never for more than 16 cycles in a row. Both strobes last a single cycle, and both strobes only reach implemented external addresses. Bit order, turnaround timing, the suppression flag, address rewriting with its effect on later matching, and alignment after a foreign or malformed frame are shown only by the bench's directed frames. For these, the bench compares serial data and strobe cycles against values derived from the requirements.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_OP    = 3'd2,
    ST_PHY   = 3'd3,
    ST_REG   = 3'd4,
    ST_TURN  = 3'd5,
    ST_DATA  = 3'd6
  } frame_st_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  localparam int OPC_BITS  = 2;
  localparam int TURN_BITS = 2;

  // Implemented register window: low block and upper block.
  function automatic logic reg_is_impl(input logic [4:0] a,
                                       input int         low_top,
                                       input int         high_base);
    return (int'(a) <= low_top) || (int'(a) >= high_base);
  endfunction

endpackage

// File: rtl/mdio_preamble_det.sv
module mdio_preamble_det #(
  parameter int PRE_LEN = 32
) (
  input  logic mdc,
  input  logic rst_n,
  input  logic mdio_in,
  input  logic in_idle,
  output logic pre_seen,
  output logic start_ok
);
  localparam int OW = $clog2(PRE_LEN + 1);

  logic [OW-1:0] ones_q, ones_d;
  logic          seen_q, seen_d;
  logic          gap_q, gap_d;

  always_comb begin
    ones_d = ones_q;
    seen_d = seen_q;
    gap_d  = gap_q;
    if (in_idle) begin
      if (mdio_in) begin
        gap_d = 1'b1;
        if (ones_q != OW'(PRE_LEN)) ones_d = ones_q + 1'b1;
        if (ones_q == OW'(PRE_LEN - 1)) seen_d = 1'b1;
      end else begin
        gap_d  = 1'b0;
        ones_d = '0;
      end
    end else begin
      gap_d  = 1'b0;
      ones_d = '0;
    end
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      seen_q <= 1'b0;
      gap_q  <= 1'b0;
    end else begin
      ones_q <= ones_d;
      seen_q <= seen_d;
      gap_q  <= gap_d;
    end
  end

  assign pre_seen = seen_q;
  assign start_ok = seen_q && gap_q;

endmodule

// File: rtl/mdio_addr_reg.sv
module mdio_addr_reg #(
  parameter int STRAP_W = 3,
  parameter int PORT_W  = 2,
  localparam int AW     = STRAP_W + PORT_W
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic [PORT_W-1:0]  port_num,
  input  logic               load,
  input  logic [AW-1:0]      load_val,
  output logic [AW-1:0]      phy_addr
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) addr_d = load_val;
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) addr_q <= {strap_addr, port_num};
    else        addr_q <= addr_d;
  end

  assign phy_addr = addr_q;

endmodule

// File: rtl/mdio_reg_mux.sv
module mdio_reg_mux
  import mdio_pkg::*;
#(
  parameter int            DATA_W    = 16,
  parameter int            REG_AW    = 5,
  parameter int            PHY_AW    = 5,
  parameter logic [4:0]    ADDR_REG  = 5'h19,
  parameter logic [4:0]    STAT_REG  = 5'h01,
  parameter int            SUPP_BIT  = 6,
  parameter int            LOW_TOP   = 6,
  parameter int            HIGH_BASE = 16
) (
  input  logic              rd_req,
  input  logic              wr_pulse,
  input  logic [REG_AW-1:0] regad,
  input  logic [DATA_W-1:0] ext_rdata,
  input  logic [PHY_AW-1:0] phy_addr,
  output logic              ext_rd,
  output logic              ext_we,
  output logic              addr_load,
  output logic [DATA_W-1:0] rd_data
);
  logic impl, is_local;

  assign impl     = reg_is_impl(regad, LOW_TOP, HIGH_BASE);
  assign is_local = (regad == ADDR_REG);

  assign ext_rd    = rd_req   && impl && !is_local;
  assign ext_we    = wr_pulse && impl && !is_local;
  assign addr_load = wr_pulse && is_local;

  always_comb begin
    rd_data = '0;
    if (is_local) begin
      rd_data[PHY_AW-1:0] = phy_addr;
    end else if (impl) begin
      rd_data = ext_rdata;
      if (regad == STAT_REG) rd_data[SUPP_BIT] = 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_AW = 5,
  parameter int PHY_AW = 5,
  localparam int CW    = $clog2(DATA_W)
) (
  input  logic              mdc,
  input  logic              rst_n,
  input  logic              mdio_in,
  input  logic              start_ok,
  input  logic [PHY_AW-1:0] phy_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              in_idle,
  output logic              data_phase,
  output logic              frame_hit,
  output logic              rd_req,
  output logic              wr_pulse,
  output logic [REG_AW-1:0] regad,
  output logic [DATA_W-1:0] wdata,
  output logic              mdio_oe,
  output logic              mdio_out
);
  frame_st_e         st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [1:0]        op_q, op_d;
  logic              hit_q, hit_d;
  logic [REG_AW-1:0] ra_q, ra_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              oe_q, oe_d;
  logic              out_q, out_d;
  logic              we_q, we_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {sh_q[DATA_W-2:0], mdio_in};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_next;
    op_d  = op_q;
    hit_d = hit_q;
    ra_d  = ra_q;
    tx_d  = tx_q;
    oe_d  = oe_q;
    out_d = out_q;
    we_d  = 1'b0;
    wd_d  = wd_q;
    unique case (st_q)
      ST_IDLE: begin
        oe_d = 1'b0;
        if (start_ok && !mdio_in) st_d = ST_START;
      end
      ST_START: begin
        cnt_d = '0;
        st_d  = mdio_in ? ST_OP : ST_IDLE;
      end
      ST_OP: begin
        if (cnt_q == CW'(OPC_BITS - 1)) begin
          op_d  = sh_next[1:0];
          cnt_d = '0;
          st_d  = ST_PHY;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PHY: begin
        if (cnt_q == CW'(PHY_AW - 1)) begin
          hit_d = (sh_next[PHY_AW-1:0] == phy_addr) &&
                  ((op_q == OPC_READ) || (op_q == OPC_WRITE));
          cnt_d = '0;
          st_d  = ST_REG;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_REG: begin
        if (cnt_q == CW'(REG_AW - 1)) begin
          ra_d  = sh_next[REG_AW-1:0];
          cnt_d = '0;
          st_d  = ST_TURN;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt_q == CW'(TURN_BITS - 1)) begin
          cnt_d = '0;
          st_d  = ST_DATA;
          if (hit_q && (op_q == OPC_READ)) begin
            oe_d  = 1'b1;
            out_d = tx_q[DATA_W-1];
            tx_d  = {tx_q[DATA_W-2:0], 1'b0};
          end
        end else begin
          tx_d  = rd_data;
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        out_d = tx_q[DATA_W-1];
        tx_d  = {tx_q[DATA_W-2:0], 1'b0};
        if (cnt_q == CW'(DATA_W - 1)) begin
          oe_d  = 1'b0;
          cnt_d = '0;
          st_d  = ST_IDLE;
          if (hit_q && (op_q == OPC_WRITE)) begin
            we_d = 1'b1;
            wd_d = sh_next;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
        oe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      op_q  <= '0;
      hit_q <= 1'b0;
      ra_q  <= '0;
      tx_q  <= '0;
      oe_q  <= 1'b0;
      out_q <= 1'b0;
      we_q  <= 1'b0;
      wd_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      op_q  <= op_d;
      hit_q <= hit_d;
      ra_q  <= ra_d;
      tx_q  <= tx_d;
      oe_q  <= oe_d;
      out_q <= out_d;
      we_q  <= we_d;
      wd_q  <= wd_d;
    end
  end

  assign in_idle    = (st_q == ST_IDLE);
  assign data_phase = (st_q == ST_DATA);
  assign frame_hit  = hit_q;
  assign rd_req     = (st_q == ST_TURN) && (cnt_q == '0) && hit_q && (op_q == OPC_READ);
  assign wr_pulse   = we_q;
  assign regad      = ra_q;
  assign wdata      = wd_q;
  assign mdio_oe    = oe_q;
  assign mdio_out   = out_q;

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int         DATA_W    = 16,
  parameter int         REG_AW    = 5,
  parameter int         STRAP_W   = 3,
  parameter int         PORT_W    = 2,
  parameter int         PRE_LEN   = 32,
  parameter logic [4:0] ADDR_REG  = 5'h19,
  parameter logic [4:0] STAT_REG  = 5'h01,
  parameter int         SUPP_BIT  = 6,
  parameter int         LOW_TOP   = 6,
  parameter int         HIGH_BASE = 16,
  localparam int        PHY_AW    = STRAP_W + PORT_W
) (
  input  logic               mdc,
  input  logic               rst_n,
  input  logic               mdio_in,
  input  logic [STRAP_W-1:0] strap_addr,
  input  logic [PORT_W-1:0]  port_num,
  output logic               mdio_oe,
  output logic               mdio_out,
  output logic [REG_AW-1:0]  reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_rd,
  input  logic [DATA_W-1:0]  reg_rdata
);
  logic              in_idle, pre_seen, start_ok;
  logic              data_phase, frame_hit, rd_req, wr_pulse, addr_load;
  logic [PHY_AW-1:0] phy_addr;
  logic [DATA_W-1:0] rd_data, wdata;
  logic [REG_AW-1:0] regad;

  mdio_preamble_det #(.PRE_LEN(PRE_LEN)) u_pre (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .in_idle(in_idle),
    .pre_seen(pre_seen), .start_ok(start_ok)
  );

  mdio_frame_fsm #(.DATA_W(DATA_W), .REG_AW(REG_AW), .PHY_AW(PHY_AW)) u_fsm (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .start_ok(start_ok),
    .phy_addr(phy_addr), .rd_data(rd_data), .in_idle(in_idle),
    .data_phase(data_phase), .frame_hit(frame_hit), .rd_req(rd_req),
    .wr_pulse(wr_pulse), .regad(regad), .wdata(wdata),
    .mdio_oe(mdio_oe), .mdio_out(mdio_out)
  );

  mdio_addr_reg #(.STRAP_W(STRAP_W), .PORT_W(PORT_W)) u_addr (
    .mdc(mdc), .rst_n(rst_n), .strap_addr(strap_addr), .port_num(port_num),
    .load(addr_load), .load_val(wdata[PHY_AW-1:0]), .phy_addr(phy_addr)
  );

  mdio_reg_mux #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .PHY_AW(PHY_AW), .ADDR_REG(ADDR_REG),
    .STAT_REG(STAT_REG), .SUPP_BIT(SUPP_BIT), .LOW_TOP(LOW_TOP),
    .HIGH_BASE(HIGH_BASE)
  ) u_mux (
    .rd_req(rd_req), .wr_pulse(wr_pulse), .regad(regad),
    .ext_rdata(reg_rdata), .phy_addr(phy_addr), .ext_rd(reg_rd),
    .ext_we(reg_we), .addr_load(addr_load), .rd_data(rd_data)
  );

  assign reg_addr  = regad;
  assign reg_wdata = wdata;

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk #(
  parameter int         DATA_W    = 16,
  parameter int         REG_AW    = 5,
  parameter logic [4:0] ADDR_REG  = 5'h19,
  parameter int         LOW_TOP   = 6,
  parameter int         HIGH_BASE = 16
) (
  input logic              mdc,
  input logic              rst_n,
  input logic              mdio_oe,
  input logic              reg_we,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic              pre_seen,
  input logic              data_phase,
  input logic              frame_hit
);
  localparam int RW = $clog2(DATA_W + 2);
  logic [RW-1:0] oe_run;
  logic          addr_impl;

  assign addr_impl = ((int'(reg_addr) <= LOW_TOP) || (int'(reg_addr) >= HIGH_BASE))
                     && (reg_addr != ADDR_REG);

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n)                          oe_run <= '0;
    else if (!mdio_oe)                   oe_run <= '0;
    else if (oe_run != RW'(DATA_W + 1))  oe_run <= oe_run + 1'b1;
  end

  // R2
  pre_gate_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    !pre_seen |-> (!mdio_oe && !reg_we && !reg_rd));

  // R4
  oe_phase_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (data_phase && frame_hit));

  // R4
  oe_len_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    oe_run <= RW'(DATA_W));

  // R5
  we_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R12
  rd_pulse_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R11
  we_addr_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_we |-> addr_impl);

  // R11
  rd_addr_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |-> addr_impl);

  // R6
  rd_hit_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    reg_rd |-> frame_hit);

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
  .DATA_W(DATA_W), .REG_AW(REG_AW), .ADDR_REG(ADDR_REG),
  .LOW_TOP(LOW_TOP), .HIGH_BASE(HIGH_BASE)
) chk_i (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .reg_we(reg_we),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .pre_seen(pre_seen),
  .data_phase(data_phase), .frame_hit(frame_hit)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb_top;
  localparam time CLK_P = 10ns;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_drv = 1'b0;
  logic        mdio_bus;
  logic        mdio_oe, mdio_out, reg_we, reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  int          errors = 0, checks = 0;
  int          we_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  logic        done = 1'b0;

  always #(CLK_P/2) mdc = ~mdc;

  assign mdio_bus  = mdio_oe ? mdio_out : m_drv;
  assign reg_rdata = {4'hC, 7'h00, reg_addr} ^ 16'h0A10;

  mdio_mgmt_slave dut_i (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_bus),
    .strap_addr(3'b101), .port_num(2'b10),
    .mdio_oe(mdio_oe), .mdio_out(mdio_out), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  always @(negedge mdc) begin
    if (reg_we)  we_cnt++;
    if (reg_rd)  rd_cnt++;
    if (mdio_oe) oe_cnt++;
  end

  function automatic logic [15:0] ext_val(input logic [4:0] a);
    return {4'hC, 7'h00, a} ^ 16'h0A10;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bitw(input logic b);
    @(negedge mdc);
    m_drv = b;
    @(posedge mdc);
  endtask

  task automatic send_hdr(input int pre, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra);
    repeat (pre) bitw(1'b1);
    bitw(1'b0); bitw(1'b1);
    for (int i = 1; i >= 0; i--) bitw(op[i]);
    for (int i = 4; i >= 0; i--) bitw(pa[i]);
    for (int i = 4; i >= 0; i--) bitw(ra[i]);
  endtask

  task automatic do_read(input string req, input int pre, input logic [4:0] pa,
                         input logic [4:0] ra, input logic drive,
                         input logic [15:0] exp, input logic exp_rd);
    logic [15:0] got;
    int          oe0;
    logic        rd_seen, oe_ta1;
    got = '0;
    oe0 = oe_cnt;
    send_hdr(pre, 2'b10, pa, ra);
    @(negedge mdc);
    m_drv   = 1'b1;
    rd_seen = reg_rd;
    oe_ta1  = mdio_oe;
    if (exp_rd) chk(req, "read strobe address", 32'(reg_addr), 32'(ra));
    chk(req, "read strobe in first turnaround", 32'(rd_seen), 32'(exp_rd));
    chk(req, "oe in first turnaround", 32'(oe_ta1), 32'd0);
    @(posedge mdc);
    @(negedge mdc);
    chk(req, "oe in second turnaround", 32'(mdio_oe), 32'd0);
    @(posedge mdc);
    for (int j = 0; j < 16; j++) begin
      @(negedge mdc);
      got = {got[14:0], mdio_out};
      if (drive) chk(req, "oe during data", 32'(mdio_oe), 32'd1);
      @(posedge mdc);
    end
    @(negedge mdc);
    chk(req, "oe released after data", 32'(mdio_oe), 32'd0);
    if (drive) chk(req, "read data", 32'(got), 32'(exp));
    else       chk(req, "no drive cycles", 32'(oe_cnt - oe0), 32'd0);
  endtask

  task automatic do_write(input string req, input int pre, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] data, input logic exp_we);
    int we0, oe0;
    we0 = we_cnt;
    oe0 = oe_cnt;
    send_hdr(pre, op, pa, ra);
    bitw(1'b1); bitw(1'b0);
    for (int i = 15; i >= 0; i--) bitw(data[i]);
    @(negedge mdc);
    m_drv = 1'b1;
    chk(req, "write strobe after last bit", 32'(reg_we), 32'(exp_we));
    if (exp_we) begin
      chk(req, "write address", 32'(reg_addr), 32'(ra));
      chk(req, "write data", 32'(reg_wdata), 32'(data));
    end
    @(negedge mdc);
    #1;
    chk(req, "write strobe count", 32'(we_cnt - we0), 32'(exp_we));
    chk(req, "no drive on write", 32'(oe_cnt - oe0), 32'd0);
  endtask

  task automatic t_reset;
    @(negedge mdc);
    chk("R1", "oe at reset", 32'(mdio_oe), 32'd0);
    chk("R1", "we at reset", 32'(reg_we), 32'd0);
    chk("R1", "rd at reset", 32'(reg_rd), 32'd0);
  endtask

  task automatic t_short_preamble;
    do_read("R2", 31, 5'h16, 5'h05, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic t_first_read;
    do_read("R4", 32, 5'h16, 5'h05, 1'b1, ext_val(5'h05), 1'b1);
  endtask

  task automatic t_write_nopre;
    do_write("R3", 0, 2'b01, 5'h16, 5'h02, 16'h3C5A, 1'b1);
    do_write("R5", 0, 2'b01, 5'h16, 5'h11, 16'h8001, 1'b1);
  endtask

  task automatic t_status;
    do_read("R9", 0, 5'h16, 5'h01, 1'b1, ext_val(5'h01) | 16'h0040, 1'b1);
  endtask

  task automatic t_unimpl;
    do_read("R11", 0, 5'h16, 5'h0A, 1'b1, 16'h0000, 1'b0);
    do_write("R11", 0, 2'b01, 5'h16, 5'h07, 16'h1234, 1'b0);
    do_read("R11", 0, 5'h16, 5'h1F, 1'b1, ext_val(5'h1F), 1'b1);
    do_read("R12", 0, 5'h16, 5'h06, 1'b1, ext_val(5'h06), 1'b1);
  endtask

  task automatic t_bad_op;
    do_write("R7", 0, 2'b11, 5'h16, 5'h02, 16'hFFFF, 1'b0);
    do_write("R7", 0, 2'b00, 5'h16, 5'h03, 16'h5555, 1'b0);
  endtask

  task automatic t_mismatch;
    do_write("R6", 0, 2'b01, 5'h05, 5'h02, 16'hBEEF, 1'b0);
    do_read("R6", 0, 5'h17, 5'h02, 1'b0, 16'h0, 1'b0);
    do_read("R6", 0, 5'h16, 5'h03, 1'b1, ext_val(5'h03), 1'b1);
  endtask

  task automatic t_single_idle;
    do_write("R8", 0, 2'b01, 5'h16, 5'h04, 16'h0F0F, 1'b1);
    do_read("R8", 0, 5'h16, 5'h04, 1'b1, ext_val(5'h04), 1'b1);
  endtask

  task automatic t_addr_reg;
    do_read("R1", 0, 5'h16, 5'h19, 1'b1, 16'h0016, 1'b0);
    do_write("R10", 0, 2'b01, 5'h16, 5'h19, 16'h0003, 1'b0);
    do_read("R10", 0, 5'h03, 5'h19, 1'b1, 16'h0003, 1'b0);
    do_read("R10", 0, 5'h16, 5'h05, 1'b0, 16'h0, 1'b0);
    do_read("R10", 0, 5'h03, 5'h05, 1'b1, ext_val(5'h05), 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge mdc);
    @(negedge mdc);
    rst_n = 1'b1;
    t_reset();
    t_short_preamble();
    t_first_read();
    t_write_nopre();
    t_status();
    t_unimpl();
    t_bad_op();
    t_mismatch();
    t_single_idle();
    t_addr_reg();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge mdc);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule